// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block is a passive observer placed beside the command bus of a two-bank SDRAM. On each rising clock edge it samples the clock-enable, chip-select, row-strobe, column-strobe, write-enable, bank-select and A10 pins. It decodes the command and keeps a per-bank state machine with a countdown timer. It reports each bank's state on a packed vector. When a command is not legal in the current state of the bank or device, it raises a sticky error flag and records a 4-bit code for the first violation.

Each bank has eight states. IDLE is precharged with nothing running. ROW has an open row and no burst. RD and WR are plain bursts. RDA and WRA are bursts with auto precharge. PRE is a precharge in progress. REF is an auto refresh in progress.

The named transitions are:
- open: IDLE to ROW on ACTIVE.
- burst start: ROW to RD, WR, RDA or WRA.
- burst end: RD or WR to ROW when the counter expires.
- auto close: RDA or WRA to PRE.
- close: ROW, RD or WR to PRE on PRECHARGE.
- interrupt: RD or WR to ROW, and RDA or WRA to PRE, when a READ or WRITE goes to the other bank.
- terminate: RD or WR to ROW on BURST TERMINATE.
- settle: PRE to IDLE.
- refresh start: IDLE to REF, taken by both banks together.
- refresh end: REF to IDLE.

An illegal command is logged. The bank affected then behaves as if it had seen a NOP.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command comes from {cs_n, ras_n, cas_n, we_n}, with these codes:
  - 0111 NOP
  - 0011 ACTIVE
  - 0101 READ
  - 0100 WRITE
  - 0110 BURST TERMINATE
  - 0010 PRECHARGE
  - 0001 AUTO REFRESH
  - 0000 LOAD MODE

  Any code with cs_n=1 is an inhibit and changes no state, whatever the other pins carry.
- R2: Bank i's state is on bank_state[3i+2:3i], coded IDLE=0, ROW=1, RD=2, WR=3, RDA=4, WRA=5, PRE=6, REF=7. Reset puts every bank in IDLE. ACTIVE to an idle bank opens it (ROW).
- R3: A READ or WRITE to a bank in ROW enters RD or WR. With A10=1 it enters RDA or WRA instead. The bank stays there for BURST_LEN edges (default 4) and then returns to ROW. RDA and WRA go on to PRE.
- R4: PRECHARGE to a bank (BA match, or A10=1 for all banks) in ROW, RD or WR enters PRE for T_RP edges (default 2), then IDLE. PRECHARGE to an idle bank leaves it idle.
- R5: AUTO REFRESH with every bank idle moves all banks to REF for T_RC edges (default 4), then to IDLE.
- R6: In a plain burst, a READ or WRITE to the same bank restarts the burst. A READ or WRITE to the other bank ends it (ROW). BURST TERMINATE ends it (ROW). An auto-precharge burst interrupted by a READ or WRITE to the other bank goes to PRE.
- R7: A READ or WRITE to an idle bank is error code 1.
- R8: ACTIVE to a bank that already has a row open is error code 2.
- R9: Error code 3 covers two cases:
  - any command other than NOP or inhibit while the banks are in REF;
  - a command that addresses a bank in PRE (ACTIVE, READ or WRITE to it, PRECHARGE to it or to all, AUTO REFRESH, LOAD MODE).
- R10: Error code 4 covers three commands during an auto-precharge burst: PRECHARGE to that bank, BURST TERMINATE, or a READ or WRITE to the same bank.
- R11: AUTO REFRESH while some bank is not idle is code 5. LOAD MODE while some bank is not idle is code 6.
- R12: After an illegal command, each bank's state and timer move exactly as for a NOP.
- R13: An edge sampled with cke=0 freezes all bank states and timers, and its command is ignored (no error).
- R14: err_flag and err_code hold the first violation until clr_err. clr_err clears both on its edge and takes priority over any violation on that edge. When banks flag together, the lowest bank's code is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| clr_err | input | 1 | Synchronous clear of the error record |
| cke | input | 1 | Clock enable pin of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (1) | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| bank_state | output | 3*NUM_BANKS (6) | Packed per-bank state codes |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |

## Verification
Every result here is due one edge after the command that causes it: bank states, timer-driven returns and error captures are all registered once. The bench drives pins on the falling edge and samples 5 ns after the next rising edge. A timed return (burst end, settle, refresh end) is expected BURST_LEN, T_RP or T_RC sampled edges after its start. Frozen edges (cke=0) are left out of that count, so the table places each expected value on the exact edge that should change it.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

    typedef enum logic [3:0] {
        CMD_INH,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE = 3'd0,
        BK_ROW  = 3'd1,
        BK_RD   = 3'd2,
        BK_WR   = 3'd3,
        BK_RDA  = 3'd4,
        BK_WRA  = 3'd5,
        BK_PRE  = 3'd6,
        BK_REF  = 3'd7
    } bank_e;

    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_NO_ROW    = 4'd1,
        ERR_ROW_OPEN  = 4'd2,
        ERR_BUSY      = 4'd3,
        ERR_AP_CUT    = 4'd4,
        ERR_REF_BUSY  = 4'd5,
        ERR_MODE_BUSY = 4'd6
    } err_e;

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
    import sdmon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_INH;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_LMR;
            endcase
        end
    end

endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
    import sdmon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 2,
    parameter int T_RC      = 4,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  cmd_e             cmd,
    input  logic             hit,
    input  logic             a10,
    input  logic             all_idle,
    output bank_e            state,
    output logic             err,
    output err_e             code
);

    localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] LD_PRE   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_REF   = CNT_W'(T_RC - 1);

    bank_e            state_q, nxt_state;
    logic [CNT_W-1:0] cnt_q, nxt_cnt;

    logic is_exec, own_rw, other_rw, pre_me, act_me;

    always_comb begin
        is_exec  = (cmd != CMD_INH) && (cmd != CMD_NOP);
        own_rw   = ((cmd == CMD_RD) || (cmd == CMD_WR)) && hit;
        other_rw = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !hit;
        pre_me   = (cmd == CMD_PRE) && (hit || a10);
        act_me   = (cmd == CMD_ACT) && hit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= nxt_state;
            cnt_q   <= nxt_cnt;
        end
    end

    // next state and error outputs
    always_comb begin
        nxt_state = state_q;
        nxt_cnt   = cnt_q;
        err       = 1'b0;
        code      = ERR_NONE;
        if (adv) begin
            // timer progress, as for a NOP
            unique case (state_q)
                BK_RD, BK_WR: begin
                    if (cnt_q == '0) nxt_state = BK_ROW;
                    else             nxt_cnt   = cnt_q - 1'b1;
                end
                BK_RDA, BK_WRA: begin
                    if (cnt_q == '0) begin
                        nxt_state = BK_PRE;
                        nxt_cnt   = LD_PRE;
                    end else begin
                        nxt_cnt = cnt_q - 1'b1;
                    end
                end
                BK_PRE, BK_REF: begin
                    if (cnt_q == '0) nxt_state = BK_IDLE;
                    else             nxt_cnt   = cnt_q - 1'b1;
                end
                default: ;
            endcase
            // command effects
            unique case (state_q)
                BK_IDLE: begin
                    if (act_me) begin
                        nxt_state = BK_ROW;
                    end else if (own_rw) begin
                        err  = 1'b1;
                        code = ERR_NO_ROW;
                    end else if (cmd == CMD_REF && all_idle) begin
                        nxt_state = BK_REF;
                        nxt_cnt   = LD_REF;
                    end
                end
                BK_ROW, BK_RD, BK_WR: begin
                    if (act_me) begin
                        err  = 1'b1;
                        code = ERR_ROW_OPEN;
                    end else if (cmd == CMD_REF) begin
                        err  = 1'b1;
                        code = ERR_REF_BUSY;
                    end else if (cmd == CMD_LMR) begin
                        err  = 1'b1;
                        code = ERR_MODE_BUSY;
                    end else if (own_rw) begin
                        nxt_cnt = LD_BURST;
                        if (cmd == CMD_RD) nxt_state = a10 ? BK_RDA : BK_RD;
                        else               nxt_state = a10 ? BK_WRA : BK_WR;
                    end else if (pre_me) begin
                        nxt_state = BK_PRE;
                        nxt_cnt   = LD_PRE;
                    end else if (state_q != BK_ROW && (other_rw || cmd == CMD_BST)) begin
                        nxt_state = BK_ROW;
                    end
                end
                BK_RDA, BK_WRA: begin
                    if (act_me) begin
                        err  = 1'b1;
                        code = ERR_ROW_OPEN;
                    end else if (cmd == CMD_REF) begin
                        err  = 1'b1;
                        code = ERR_REF_BUSY;
                    end else if (cmd == CMD_LMR) begin
                        err  = 1'b1;
                        code = ERR_MODE_BUSY;
                    end else if (own_rw || pre_me || cmd == CMD_BST) begin
                        err  = 1'b1;
                        code = ERR_AP_CUT;
                    end else if (other_rw) begin
                        nxt_state = BK_PRE;
                        nxt_cnt   = LD_PRE;
                    end
                end
                BK_PRE: begin
                    if (act_me || own_rw || pre_me || cmd == CMD_REF || cmd == CMD_LMR) begin
                        err  = 1'b1;
                        code = ERR_BUSY;
                    end
                end
                BK_REF: begin
                    if (is_exec) begin
                        err  = 1'b1;
                        code = ERR_BUSY;
                    end
                end
                default: ;
            endcase
        end
    end

    assign state = state_q;

    // R13
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q) && $stable(cnt_q));

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_IDLE) |=> (state_q inside {BK_IDLE, BK_ROW, BK_REF}));

    // R5
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_REF && cnt_q != '0) |=> (state_q == BK_REF));

    // R3
    burst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {BK_RD, BK_WR}) |=> (state_q inside {BK_RD, BK_WR, BK_RDA, BK_WRA, BK_ROW, BK_PRE}));

endmodule

// File: rtl/sdmon_errlog.sv
module sdmon_errlog
    import sdmon_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [NUM_BANKS-1:0]   err_v,
    input  logic [4*NUM_BANKS-1:0] code_v,
    output logic                   flag,
    output logic [3:0]             code
);

    logic       any_err;
    logic [3:0] pick;
    logic       flag_q;
    logic [3:0] code_q;

    // lowest bank index wins
    always_comb begin
        any_err = 1'b0;
        pick    = ERR_NONE;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (err_v[i]) begin
                any_err = 1'b1;
                pick    = code_v[4*i +: 4];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            code_q <= ERR_NONE;
        end else if (clr) begin
            flag_q <= 1'b0;
            code_q <= ERR_NONE;
        end else if (!flag_q && any_err) begin
            flag_q <= 1'b1;
            code_q <= pick;
        end
    end

    assign flag = flag_q;
    assign code = code_q;

    // R14
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> (flag_q && $stable(code_q)));

    // R14
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q == (code_q != ERR_NONE));

    // R14
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag_q);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdmon_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 2,
    parameter int T_RC      = 4,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_err,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic [3*NUM_BANKS-1:0] bank_state,
    output logic                   err_flag,
    output logic [3:0]             err_code
);

    localparam int MAX_AB = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
    localparam int MAX_T  = (MAX_AB > T_RC) ? MAX_AB : T_RC;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    cmd_e                   cmd;
    bank_e                  st    [NUM_BANKS];
    logic [NUM_BANKS-1:0]   b_err;
    logic [4*NUM_BANKS-1:0] b_code;
    logic                   all_idle;

    sdmon_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (st[i] != BK_IDLE) all_idle = 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        err_e code_g;
        sdmon_bank #(
            .BURST_LEN (BURST_LEN),
            .T_RP      (T_RP),
            .T_RC      (T_RC),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (cke),
            .cmd      (cmd),
            .hit      (ba == BA_W'(g)),
            .a10      (a10),
            .all_idle (all_idle),
            .state    (st[g]),
            .err      (b_err[g]),
            .code     (code_g)
        );
        assign b_code[4*g +: 4]     = code_g;
        assign bank_state[3*g +: 3] = st[g];
    end

    sdmon_errlog #(
        .NUM_BANKS (NUM_BANKS)
    ) u_errlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_err),
        .err_v  (b_err),
        .code_v (b_code),
        .flag   (err_flag),
        .code   (err_code)
    );

    // R5
    ref_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] == BK_REF) == (st[NUM_BANKS-1] == BK_REF));

    // R13
    frozen_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !clr_err) |=> $stable(err_flag) && $stable(err_code));

endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_err = 1'b0;
    logic       cke = 1'b1;
    logic [3:0] pins = 4'b1111;
    logic       ba = 1'b0;
    logic       a10 = 1'b0;
    logic [5:0] bank_state;
    logic       err_flag;
    logic [3:0] err_code;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sdram_cmd_monitor i_sdram_cmd_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_err    (clr_err),
        .cke        (cke),
        .cs_n       (pins[3]),
        .ras_n      (pins[2]),
        .cas_n      (pins[1]),
        .we_n       (pins[0]),
        .ba         (ba),
        .a10        (a10),
        .bank_state (bank_state),
        .err_flag   (err_flag),
        .err_code   (err_code)
    );

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_BST = 4'b0110;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_INA = 4'b1011;

    // {cke, cmd, ba, a10, clr, s1, s0, flag, code, req}
    localparam int NV = 64;
    localparam logic [22:0] TBL [NV] = '{
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 4'd0, 4'd1},  // R1
        {1'b1, C_ACT, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 4'd0, 4'd2},  // R2
        {1'b1, C_ACT, 1'b1, 1'b0, 1'b0, 3'd1, 3'd1, 1'b0, 4'd0, 4'd2},
        {1'b1, C_RD,  1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b0, 4'd0, 4'd3},  // R3
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1, 1'b0, 4'd0, 4'd3},
        {1'b1, C_WR,  1'b1, 1'b1, 1'b0, 3'd5, 3'd1, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd5, 3'd1, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd5, 3'd1, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd5, 3'd1, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd6, 3'd1, 1'b0, 4'd0, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd6, 3'd1, 1'b0, 4'd0, 4'd4},  // R4
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 4'd0, 4'd4},
        {1'b1, C_RD,  1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 1'b0, 4'd0, 4'd3},
        {1'b1, C_WR,  1'b0, 1'b0, 1'b0, 3'd0, 3'd3, 1'b0, 4'd0, 4'd6},  // R6
        {1'b1, C_BST, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 4'd0, 4'd6},
        {1'b1, C_PRE, 1'b0, 1'b1, 1'b0, 3'd0, 3'd6, 1'b0, 4'd0, 4'd4},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd6, 1'b0, 4'd0, 4'd4},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 4'd0, 4'd4},
        {1'b1, C_REF, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b0, 4'd0, 4'd5},  // R5
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b0, 4'd0, 4'd5},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b0, 4'd0, 4'd5},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b0, 4'd0, 4'd5},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 4'd0, 4'd5},
        {1'b1, C_RD,  1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 4'd1, 4'd7},  // R7
        {1'b1, C_ACT, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 1'b0, 4'd0, 4'd14}, // R14
        {1'b1, C_ACT, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b1, 4'd2, 4'd8},  // R8
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 1'b0, 4'd0, 4'd14},
        {1'b1, C_RD,  1'b0, 1'b1, 1'b0, 3'd0, 3'd4, 1'b0, 4'd0, 4'd3},
        {1'b1, C_PRE, 1'b0, 1'b0, 1'b0, 3'd0, 3'd4, 1'b1, 4'd4, 4'd10}, // R10
        {1'b1, C_REF, 1'b0, 1'b0, 1'b0, 3'd0, 3'd4, 1'b1, 4'd4, 4'd14},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd4, 1'b1, 4'd4, 4'd12}, // R12
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd6, 1'b1, 4'd4, 4'd3},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b1, 3'd0, 3'd6, 1'b0, 4'd0, 4'd14},
        {1'b1, C_ACT, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 4'd3, 4'd9},  // R9
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 4'd0, 4'd14},
        {1'b1, C_ACT, 1'b1, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 4'd0, 4'd2},
        {1'b1, C_LMR, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 1'b1, 4'd6, 4'd11}, // R11
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0, 4'd0, 4'd14},
        {1'b0, C_ACT, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 4'd0, 4'd13}, // R13
        {1'b0, C_RD,  1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 4'd0, 4'd13},
        {1'b1, C_RD,  1'b1, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 4'd0, 4'd3},
        {1'b0, C_NOP, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 4'd0, 4'd13},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 4'd0, 4'd13},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 4'd0, 4'd13},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 4'd0, 4'd13},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 4'd0, 4'd13},
        {1'b1, C_PRE, 1'b1, 1'b0, 1'b0, 3'd6, 3'd0, 1'b0, 4'd0, 4'd4},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd6, 3'd0, 1'b0, 4'd0, 4'd4},
        {1'b1, C_INA, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 4'd0, 4'd1},
        {1'b1, C_REF, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b0, 4'd0, 4'd5},
        {1'b1, C_ACT, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 1'b1, 4'd3, 4'd9},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b1, 4'd3, 4'd12},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b1, 4'd3, 4'd12},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 4'd3, 4'd12},
        {1'b1, C_ACT, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 1'b0, 4'd0, 4'd14},
        {1'b1, C_ACT, 1'b1, 1'b0, 1'b0, 3'd1, 3'd1, 1'b0, 4'd0, 4'd2},
        {1'b1, C_RD,  1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b0, 4'd0, 4'd3},
        {1'b1, C_RD,  1'b1, 1'b0, 1'b0, 3'd2, 3'd1, 1'b0, 4'd0, 4'd6},
        {1'b1, C_WR,  1'b0, 1'b1, 1'b0, 3'd1, 3'd5, 1'b0, 4'd0, 4'd6},
        {1'b1, C_RD,  1'b1, 1'b0, 1'b0, 3'd2, 3'd6, 1'b0, 4'd0, 4'd6},
        {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 3'd2, 3'd6, 1'b0, 4'd0, 4'd4}
    };

    task automatic drive(input logic k, input logic [3:0] c, input logic b,
                         input logic a, input logic cl);
        @(negedge clk);
        cke     = k;
        pins    = c;
        ba      = b;
        a10     = a;
        clr_err = cl;
        @(posedge clk);
        #5;
    endtask

    task automatic check(input int req, input logic [5:0] es, input logic ef,
                         input logic [3:0] ec);
        total++;
        if (bank_state !== es || err_flag !== ef || err_code !== ec) begin
            bad++;
            $display("FAIL R%0d: state=%h flag=%b code=%0d, expected state=%h flag=%b code=%0d",
                     req, bank_state, err_flag, err_code, es, ef, ec);
        end
    endtask

    initial begin
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check(2, 6'd0, 1'b0, 4'd0);  // R2 reset state
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            drive(TBL[v][22], TBL[v][21:18], TBL[v][17], TBL[v][16], TBL[v][15]);
            check(int'(TBL[v][3:0]), {TBL[v][14:12], TBL[v][11:9]}, TBL[v][8], TBL[v][7:4]);
        end

        // R3 remaining burst on bank 1 runs out to row open
        drive(1'b1, C_NOP, 1'b0, 1'b0, 1'b0);
        check(3, {3'd2, 3'd0}, 1'b0, 4'd0);
        drive(1'b1, C_NOP, 1'b0, 1'b0, 1'b0);
        drive(1'b1, C_NOP, 1'b0, 1'b0, 1'b0);
        check(3, {3'd1, 3'd0}, 1'b0, 4'd0);

        // R10 burst terminate during auto-precharge read
        drive(1'b1, C_RD, 1'b1, 1'b1, 1'b0);
        check(3, {3'd4, 3'd0}, 1'b0, 4'd0);
        drive(1'b1, C_BST, 1'b0, 1'b0, 1'b0);
        check(10, {3'd4, 3'd0}, 1'b1, 4'd4);

        // R2 reset mid-run returns every bank to idle and clears the log
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check(2, 6'd0, 1'b0, 4'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule